// File: doc/BRIEF.md
# Two-Tone FSK Audio Demodulator

This block turns a one-bit sliced audio waveform carrying a 1200 Hz / 2200 Hz frequency-shift-keyed signal into a raw data level. The input is resynchronised into the system clock domain. The block counts sample ticks from a fixed-rate internal tick between successive transitions, so each measured half-period of the waveform is classed as the low tone or the high tone. The low tone (1200 Hz) drives the data output to 1 and the high tone (2200 Hz) drives it to 0. No bit-rate recovery or framing is done: the output level follows every classified half-period directly.

An active-low carrier flag reports whether a steady stream of in-band half-periods is present. A single-cycle pulse marks every 1-to-0 step of the data output so that software or a neighbouring interrupt block can time its decoding. A power-enable input gates the whole block. While it is low, the block idles in a fixed state. After it rises, the carrier flag is held invalid until a settling period has elapsed.

With default parameters the tick runs at 52 800 Hz. A half-period is then 22 ticks for the low tone and 12 ticks for the high tone. The mark/space threshold sits at 16 ticks (about 1650 Hz) and the valid window is 10 to 26 ticks (about 2600 Hz down to 1000 Hz).

Top module: `fsk_tone_demod`

## Requirements
- R1: A half-period of more than MID ticks (MID = SAMPLE_HZ/3300, 16 by default) that lies inside the valid window sets data_o to 1. A steady 1200 Hz tone of 22-tick half-periods gives data_o = 1.
- R2: A half-period inside the valid window of at most MID ticks sets data_o to 0. A steady 2200 Hz tone of 12-tick half-periods gives data_o = 0.
- R3: The boundaries are exact. With defaults, 17 ticks is mark (1) and 16 ticks is space (0). The valid window is 10 to 26 ticks inclusive (SAMPLE_HZ/5200 to SAMPLE_HZ/2000), so 26 and 10 are both decoded.
- R4: A half-period outside the valid window (with defaults, 9 ticks or fewer, or 27 ticks or more) leaves data_o unchanged.
- R5: cd_n_o goes low once 4 consecutive half-periods have fallen inside the window and the settling period is over. It returns high after 4 consecutive out-of-window half-periods, or after 4×(SAMPLE_HZ/2000) ticks (104 by default) with no input transition.
- R6: After pwr_en rises, cd_n_o stays high until SETUP_TICKS ticks have elapsed, even when a valid tone is present.
- R7: fall_o is high for exactly one clock on each 1-to-0 step of data_o while powered, and at no other time.
- R8: While pwr_en is 0, data_o is 1, cd_n_o is 1, fall_o is 0, and input transitions have no effect. The first transition after power-up or after a timeout only starts a measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en | input | 1 | 1 = decoder running, 0 = decoder powered down |
| fsk_in | input | 1 | Sliced audio waveform, asynchronous to clk |
| data_o | output | 1 | Raw decoded level: 1 = 1200 Hz, 0 = 2200 Hz |
| cd_n_o | output | 1 | Carrier detect, low = in-band tone present |
| fall_o | output | 1 | One-clock pulse on each 1-to-0 step of data_o |

## Verification
The assertions take for granted that fsk_in changes far more slowly than the tick, so that two synchronised edges never fall within one measurement. They also assume pwr_en and rst_n are plain synchronous levels. The bench toggles fsk_in only on falling clock edges, at whole multiples of the tick divider, so every measured half-period is an exact tick count. Every burst also stays well above the two-flop synchroniser latency. When the bench pauses to sample, it shortens the next gap by the paused cycles, so sampling never lengthens an interval. The only exception is the deliberate silence that exercises the timeout.

// File: rtl/fsk_demod_pkg.sv
// Package fsk_demod_pkg
// Shared constants, the interval record passed from the half-period timer
// to its consumers, and a helper that converts a tone frequency into a
// half-period length in sample ticks.
package fsk_demod_pkg;

    // Result of one measured half-period.
    typedef struct packed {
        logic stb;   // one-cycle strobe: a measurement completed
        logic ok;    // the length lies inside the valid window
        logic mark;  // the length is above the mark/space threshold
    } ivl_t;

    // Half-period of a tone in ticks of a sample clock (rounded down).
    function automatic int half_ticks(input int sample_hz, input int tone_hz);
        return sample_hz / (2 * tone_hz);
    endfunction

    localparam int F_WIN_LO = 1000;  // lowest accepted tone, Hz
    localparam int F_MID    = 1650;  // mark/space decision frequency, Hz
    localparam int F_WIN_HI = 2600;  // highest accepted tone, Hz

endpackage

// File: rtl/fsk_tick_gen.sv
// Module fsk_tick_gen
// Divides the system clock into a one-cycle sample tick every DIV clocks.
// Assumes DIV >= 1. The divider is held cleared while run is low.
module fsk_tick_gen #(
    parameter int DIV = 947
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Count clocks and emit a tick when the divider wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q  <= '0;
            tick_o <= 1'b0;
        end else if (div_q == LAST) begin
            div_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/fsk_in_sync.sv
// Module fsk_in_sync
// Brings the asynchronous sliced input into the clock domain through a
// STAGES-deep flop chain and flags every change of the synchronised level.
// Assumes STAGES >= 2. Not gated by power, so that powering up produces
// no false edge.
module fsk_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign edge_o = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/fsk_half_timer.sv
// Module fsk_half_timer
// Counts sample ticks between successive input edges. On each edge it
// reports the length: valid or not, and mark or space. The first edge
// after run rises, or after a timeout, only arms the timer. A stretch of
// TMO ticks without an edge raises a one-cycle timeout.
// Assumes edges are at least a few ticks apart.
module fsk_half_timer
    import fsk_demod_pkg::*;
#(
    parameter int MIN_T = 10,
    parameter int MID_T = 16,
    parameter int MAX_T = 26,
    parameter int TMO   = 104
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic edge_i,
    output ivl_t ivl_o,
    output logic tmo_o
);
    localparam int CW = $clog2(TMO + 1);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_T);
    localparam logic [CW-1:0] MID_C = CW'(MID_T);
    localparam logic [CW-1:0] MAX_C = CW'(MAX_T);
    localparam logic [CW-1:0] TMO_C = CW'(TMO);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    // Measure intervals, classify them on each edge, detect silence.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            ivl_o   <= '0;
            tmo_o   <= 1'b0;
        end else begin
            ivl_o.stb <= 1'b0;
            tmo_o     <= 1'b0;
            if (edge_i) begin
                ivl_o.stb  <= armed_q;
                ivl_o.ok   <= (cnt_q >= MIN_C) && (cnt_q <= MAX_C);
                ivl_o.mark <= (cnt_q > MID_C);
                cnt_q      <= tick ? CW'(1) : '0;
                armed_q    <= 1'b1;
            end else if (tick && cnt_q != TMO_C) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == TMO_C - 1'b1 && armed_q) begin
                    tmo_o   <= 1'b1;
                    armed_q <= 1'b0;
                end
            end
        end
    end

    // R8: a measurement is only reported on the cycle after an edge.
    assert_stb_after_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_o.stb |-> $past(edge_i));

    // R5: a timeout and a measurement never coincide.
    assert_tmo_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmo_o && ivl_o.stb));
endmodule

// File: rtl/fsk_carrier_ctl.sv
// Module fsk_carrier_ctl
// Tracks runs of valid and invalid intervals and the power-up settling
// time, and keeps the carrier-present state. Carrier is granted after
// RUN valid intervals once settled. It is withdrawn after RUN invalid
// intervals or on a timeout.
// Assumes RUN >= 1 and SETUP >= 1.
module fsk_carrier_ctl
    import fsk_demod_pkg::*;
#(
    parameter int RUN   = 4,
    parameter int SETUP = 2640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  ivl_t ivl_i,
    input  logic tmo_i,
    output logic cd_on_o
);
    localparam int RW = $clog2(RUN + 1);
    localparam int SW = $clog2(SETUP + 1);
    localparam logic [RW-1:0] RUN_C   = RW'(RUN);
    localparam logic [SW-1:0] SETUP_C = SW'(SETUP);

    logic [RW-1:0] good_q;
    logic [RW-1:0] bad_q;
    logic [SW-1:0] settle_q;
    logic          settled_q;

    // Count ticks since power-up until the settling period is over.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            settle_q  <= '0;
            settled_q <= 1'b0;
        end else if (tick && !settled_q) begin
            if (settle_q == SETUP_C - 1'b1) settled_q <= 1'b1;
            settle_q <= settle_q + 1'b1;
        end
    end

    // Keep saturating run lengths of valid and invalid intervals.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tmo_i) begin
            good_q <= '0;
            bad_q  <= '0;
        end else if (ivl_i.stb) begin
            if (ivl_i.ok) begin
                bad_q <= '0;
                if (good_q != RUN_C) good_q <= good_q + 1'b1;
            end else begin
                good_q <= '0;
                if (bad_q != RUN_C) bad_q <= bad_q + 1'b1;
            end
        end
    end

    // Grant or withdraw the carrier from the run lengths and settling.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tmo_i) begin
            cd_on_o <= 1'b0;
        end else if (bad_q == RUN_C) begin
            cd_on_o <= 1'b0;
        end else if (settled_q && good_q == RUN_C) begin
            cd_on_o <= 1'b1;
        end
    end

    // R6: carrier is never reported before the settling period ends.
    assert_cd_after_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cd_on_o |-> settled_q);

    // R5: a timeout withdraws the carrier on the next cycle.
    assert_tmo_drops_cd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_i |=> !cd_on_o);

    // R5: carrier only appears after a full run of valid intervals.
    assert_cd_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cd_on_o) |-> $past(good_q) == RUN_C);
endmodule

// File: rtl/fsk_tone_demod.sv
// Module fsk_tone_demod
// Top level of the two-tone FSK demodulator. It ties together the tick
// divider, the input synchroniser, the half-period timer and the carrier
// tracker, and holds the raw data level and its falling-edge pulse.
// Assumes fsk_in is an already sliced one-bit waveform. All thresholds
// derive from SAMPLE_HZ. The tick rate is clk / CLK_DIV and must equal
// SAMPLE_HZ.
module fsk_tone_demod
    import fsk_demod_pkg::*;
#(
    parameter int SAMPLE_HZ   = 52800,
    parameter int CLK_DIV     = 947,
    parameter int SYNC_STAGES = 2,
    parameter int CD_RUN      = 4,
    parameter int SETUP_TICKS = SAMPLE_HZ / 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic fsk_in,
    output logic data_o,
    output logic cd_n_o,
    output logic fall_o
);
    localparam int MIN_T = half_ticks(SAMPLE_HZ, F_WIN_HI);
    localparam int MID_T = half_ticks(SAMPLE_HZ, F_MID);
    localparam int MAX_T = half_ticks(SAMPLE_HZ, F_WIN_LO);
    localparam int TMO_T = 4 * MAX_T;

    logic tick;
    logic edge_s;
    ivl_t ivl;
    logic tmo;
    logic cd_on;

    fsk_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(pwr_en), .tick_o(tick)
    );

    fsk_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(fsk_in), .edge_o(edge_s)
    );

    fsk_half_timer #(
        .MIN_T(MIN_T), .MID_T(MID_T), .MAX_T(MAX_T), .TMO(TMO_T)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(pwr_en), .tick(tick),
        .edge_i(edge_s), .ivl_o(ivl), .tmo_o(tmo)
    );

    fsk_carrier_ctl #(.RUN(CD_RUN), .SETUP(SETUP_TICKS)) u_carrier (
        .clk(clk), .rst_n(rst_n), .run(pwr_en), .tick(tick),
        .ivl_i(ivl), .tmo_i(tmo), .cd_on_o(cd_on)
    );

    // Update the raw level from valid intervals and flag each 1-to-0 step.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_en) begin
            data_o <= 1'b1;
            fall_o <= 1'b0;
        end else begin
            fall_o <= 1'b0;
            if (ivl.stb && ivl.ok) begin
                data_o <= ivl.mark;
                fall_o <= data_o && !ivl.mark;
            end
        end
    end

    assign cd_n_o = ~cd_on;

    // R8: one cycle after power-down, all outputs sit at their idle levels.
    assert_pd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (data_o && cd_n_o && !fall_o));

    // R7: the pulse coincides with a low level that was high just before.
    assert_fall_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (!data_o && $past(data_o)));

    // R7: the pulse never lasts two cycles.
    assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

    // R4: while powered, the level only moves after a valid interval.
    assert_data_moves_on_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && $past(pwr_en) && data_o != $past(data_o)) |-> $past(ivl.stb && ivl.ok));
endmodule

// File: tb/sim_fsk_tone_demod.sv
// Directed bench for fsk_tone_demod. A divider of 4 clocks per tick and a
// 200-tick settling period keep the runs short.
module sim_fsk_tone_demod;
    localparam int DIV   = 4;
    localparam int SETUP = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en = 1'b0;
    logic fsk_in = 1'b0;
    logic data_o, cd_n_o, fall_o;

    int checks = 0;
    int failures = 0;
    int events = 0;
    int lag = 0;
    bit finished = 1'b0;
    bit fall_prev = 1'b0;

    always #10 clk = ~clk;

    fsk_tone_demod #(.CLK_DIV(DIV), .SETUP_TICKS(SETUP)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .fsk_in(fsk_in),
        .data_o(data_o), .cd_n_o(cd_n_o), .fall_o(fall_o)
    );

    // Count falling-edge pulses and catch a pulse that lasts two cycles (R7).
    always @(negedge clk) begin
        if (fall_o) events++;
        if (fall_o && fall_prev) begin
            failures++;
            $display("FAIL R7 pulse longer than one cycle: actual=2 expected=1");
        end
        fall_prev = fall_o;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Toggle the input n times, each after a gap of t ticks.
    task automatic burst(input int n, input int t);
        for (int i = 0; i < n; i++) begin
            repeat (t * DIV - ((i == 0) ? lag : 0)) @(negedge clk);
            fsk_in = ~fsk_in;
        end
        lag = 0;
    endtask

    // Let the pipeline settle. The next burst absorbs the delay.
    task automatic settle();
        repeat (8) @(negedge clk);
        lag += 8;
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 reset data", data_o, 1);
        check("R8 reset cd_n", cd_n_o, 1);
        check("R8 reset events", events, 0);
    endtask

    task automatic t_setup_and_mark();
        pwr_en = 1'b1;
        burst(6, 22);
        settle();
        check("R6 cd_n held during setup", cd_n_o, 1);
        check("R1 mark level", data_o, 1);
        burst(6, 22);
        settle();
        check("R5 cd_n after setup and run", cd_n_o, 0);
        check("R1 mark level kept", data_o, 1);
    endtask

    task automatic t_space();
        burst(6, 12);
        settle();
        check("R2 space level", data_o, 0);
        check("R7 one event on mark-to-space", events, 1);
        check("R5 carrier kept on space", cd_n_o, 0);
    endtask

    task automatic t_alternate();
        for (int k = 0; k < 3; k++) begin
            burst(2, 22);
            burst(2, 12);
        end
        settle();
        check("R7 events after alternation", events, 4);
        check("R2 level after alternation", data_o, 0);
    endtask

    task automatic t_threshold();
        burst(2, 17);
        settle();
        check("R3 17 ticks is mark", data_o, 1);
        burst(2, 16);
        settle();
        check("R3 16 ticks is space", data_o, 0);
        check("R7 event at threshold", events, 5);
    endtask

    task automatic t_window();
        burst(1, 26);
        settle();
        check("R3 26 ticks valid mark", data_o, 1);
        burst(1, 10);
        settle();
        check("R3 10 ticks valid space", data_o, 0);
        check("R7 event at window edge", events, 6);
    endtask

    task automatic t_invalid();
        burst(3, 27);
        settle();
        check("R4 long intervals ignored", data_o, 0);
        check("R5 carrier kept after 3 invalid", cd_n_o, 0);
        burst(1, 9);
        settle();
        check("R5 carrier lost after 4 invalid", cd_n_o, 1);
        check("R4 short interval ignored", data_o, 0);
        burst(3, 12);
        settle();
        check("R5 carrier not back after 3 valid", cd_n_o, 1);
        burst(1, 12);
        settle();
        check("R5 carrier back after 4 valid", cd_n_o, 0);
        check("R7 no event space to space", events, 6);
    endtask

    task automatic t_timeout();
        repeat (500) @(negedge clk);
        lag = 0;
        check("R5 timeout drops carrier", cd_n_o, 1);
        check("R5 timeout keeps level", data_o, 0);
    endtask

    task automatic t_power();
        pwr_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 powered-down data", data_o, 1);
        check("R8 powered-down cd_n", cd_n_o, 1);
        burst(6, 12);
        settle();
        check("R8 input ignored when down", data_o, 1);
        check("R8 no events when down", events, 6);
        lag = 0;
        pwr_en = 1'b1;
        burst(6, 12);
        settle();
        check("R2 space after power-up", data_o, 0);
        check("R7 event after power-up", events, 7);
        check("R6 cd_n held after re-power", cd_n_o, 1);
    endtask

    initial begin
        t_reset();
        t_setup_and_mark();
        t_space();
        t_alternate();
        t_threshold();
        t_window();
        t_invalid();
        t_timeout();
        t_power();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule